// File: doc/BRIEF.md
# Flash Write Engine with Suspend and Resume

This block is the self-timed write engine inside a serial flash device. It takes commands that have already been decoded and runs sector erase, block erase and page program operations. Each operation takes a fixed number of ticks of a slow timebase. While an operation is running it can be suspended. Suspending freezes the number of ticks still to go and fences off the sector, block or page being worked on. The rest of the array stays open for reads and for a second, nested write. A later resume finishes the frozen operation from where it stopped. The memory array is modelled only as a tick counter plus the address range that an operation covers.

Each command arrives as a one-cycle strobe with an 8-bit code and an address. The engine answers every command with a one-cycle accept or ignore pulse in the next cycle. A read that hits the fenced-off range is accepted but flagged as returning undefined data. The status outputs show busy, a suspended erase and a suspended program.

Top module: `flash_write_engine`

## Requirements
- R1: Each `cmd_valid_i` strobe is answered in the next cycle by exactly one of `cmd_ack_o` or `cmd_nak_o`. Neither output pulses without a strobe. The codes are 20h sector erase, D8h block erase, 02h page program, 03h read, B0h suspend and 30h resume. Any other code is ignored.
- R2: An accepted erase or program raises `busy_o` in the cycle after the strobe. `busy_o` falls in the cycle after the edge that samples the Nth `tick_i`, where N is `SEC_TICKS`, `BLK_TICKS` or `PROG_TICKS`.
- R3: An accepted suspend sets `erase_susp_o` when the running operation is an erase and `prog_susp_o` when it is a program. The flag appears in the same cycle as the accept pulse. The two flags are never high together.
- R4: After an accepted suspend, `busy_o` stays high for exactly `SUSP_LAT` cycles, counted from the cycle of the accept pulse.
- R5: While `busy_o` is high, every command except suspend is ignored.
- R6: A suspend is ignored in four cases: when no operation is running, during the suspend latency, while another operation is already suspended, and when the running operation finishes on the tick sampled in the same cycle.
- R7: A resume is ignored when nothing is suspended. An accepted resume clears the suspend flag and raises `busy_o` until the operation completes.
- R8: The ticks counted before a suspend plus the ticks counted after the resume equal the uninterrupted duration of the operation.
- R9: While an erase is suspended, a program inside the suspended sector or block is ignored. A program elsewhere is accepted. Every erase is ignored.
- R10: While a program is suspended, an erase whose sector or block contains the suspended page is ignored. An erase elsewhere is accepted. Every program is ignored.
- R11: A read is accepted while `busy_o` is low. `rd_invalid_o` pulses with the accept exactly when the read address lies inside the region of the suspended operation. A sector spans 2^`SEC_W` bytes, a block 2^`BLK_W` bytes and a page 2^`PAGE_W` bytes.
- R12: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase strobe for the self-timed counters |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_code_i | input | 8 | Command code |
| cmd_addr_i | input | ADDR_W | Byte address of the command |
| busy_o | output | 1 | Operation or suspend latency in progress |
| erase_susp_o | output | 1 | An erase is suspended |
| prog_susp_o | output | 1 | A program is suspended |
| cmd_ack_o | output | 1 | Command accepted, one cycle after the strobe |
| cmd_nak_o | output | 1 | Command ignored, one cycle after the strobe |
| rd_invalid_o | output | 1 | Accepted read returns undefined data |

## Verification
The accept pulse, the ignore pulse and the invalid-read flag are all due one cycle after the strobe. The suspend flags and the rising edge of busy change in that same cycle. Completion shows one cycle after the edge that samples the last tick. The suspend latency ends `SUSP_LAT` cycles after the accept pulse. A reference model in the bench is updated on the same edges as the design and compared at the falling clock edge. Directed checks sample one nanosecond after the edge that consumes each stimulus. Duration and latency checks count stimulus steps until busy drops and compare the count with the parameter value.

// File: rtl/flash_we_pkg.sv
package flash_we_pkg;
  typedef enum logic [1:0] {
    KIND_SEC  = 2'd0,
    KIND_BLK  = 2'd1,
    KIND_PAGE = 2'd2,
    KIND_BYTE = 2'd3
  } op_kind_e;

  localparam logic [7:0] CODE_SEC_ERASE = 8'h20;
  localparam logic [7:0] CODE_BLK_ERASE = 8'hD8;
  localparam logic [7:0] CODE_PAGE_PROG = 8'h02;
  localparam logic [7:0] CODE_READ      = 8'h03;
  localparam logic [7:0] CODE_SUSPEND   = 8'hB0;
  localparam logic [7:0] CODE_RESUME    = 8'h30;
endpackage

// File: rtl/flash_region_cmp.sv
module flash_region_cmp
  import flash_we_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned PAGE_W = 4,
  parameter int unsigned SEC_W  = 8,
  parameter int unsigned BLK_W  = 12
) (
  input  op_kind_e          kind_a_i,
  input  logic [ADDR_W-1:0] addr_a_i,
  input  op_kind_e          kind_b_i,
  input  logic [ADDR_W-1:0] addr_b_i,
  output logic              same_o
);
  function automatic int unsigned low_w(op_kind_e k);
    case (k)
      KIND_SEC:  return SEC_W;
      KIND_BLK:  return BLK_W;
      KIND_PAGE: return PAGE_W;
      default:   return 0;
    endcase
  endfunction

  int unsigned       ga, gb, g;
  logic [ADDR_W-1:0] mask;

  // overlap is decided at the coarser granularity of the two
  always_comb begin
    ga     = low_w(kind_a_i);
    gb     = low_w(kind_b_i);
    g      = (ga > gb) ? ga : gb;
    mask   = {ADDR_W{1'b1}} << g;
    same_o = ((addr_a_i ^ addr_b_i) & mask) == '0;
  end
endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] rem_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    rem_o <= '0;
    else if (load_i)                rem_o <= load_val_i;
    else if (tick_i && rem_o != '0) rem_o <= rem_o - CNT_W'(1);
  end
endmodule

// File: rtl/flash_lat_cnt.sv
module flash_lat_cnt #(
  parameter int unsigned SUSP_LAT = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned LAT_W = $clog2(SUSP_LAT + 1);

  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= LAT_W'(SUSP_LAT);
    else if (cnt_q != '0)   cnt_q <= cnt_q - LAT_W'(1);
  end

  assign busy_o = cnt_q != '0;
endmodule

// File: rtl/flash_write_engine.sv
module flash_write_engine
  import flash_we_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned PAGE_W     = 4,
  parameter int unsigned SEC_W      = 8,
  parameter int unsigned BLK_W      = 12,
  parameter int unsigned SEC_TICKS  = 40,
  parameter int unsigned BLK_TICKS  = 80,
  parameter int unsigned PROG_TICKS = 20,
  parameter int unsigned SUSP_LAT   = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cmd_valid_i,
  input  logic [7:0]        cmd_code_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  output logic              busy_o,
  output logic              erase_susp_o,
  output logic              prog_susp_o,
  output logic              cmd_ack_o,
  output logic              cmd_nak_o,
  output logic              rd_invalid_o
);
  localparam int unsigned MAX_EP = (SEC_TICKS > PROG_TICKS) ? SEC_TICKS : PROG_TICKS;
  localparam int unsigned MAX_T  = (BLK_TICKS > MAX_EP) ? BLK_TICKS : MAX_EP;
  localparam int unsigned CNT_W  = $clog2(MAX_T + 1);

  logic             is_sec, is_blk, is_prog, is_rd, is_susp, is_res;
  op_kind_e         cmd_kind;
  logic [CNT_W-1:0] rem;
  logic             running, lat_busy, finishing, hit, sus_erase;
  logic             acc_susp, acc_res, acc_erase, acc_prog, acc_rd, acc_any;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;

  op_kind_e          act_kind_q, sus_kind_q;
  logic [ADDR_W-1:0] act_addr_q, sus_addr_q;
  logic [CNT_W-1:0]  sus_rem_q;
  logic              sus_valid_q;

  always_comb begin
    is_sec  = cmd_valid_i && cmd_code_i == CODE_SEC_ERASE;
    is_blk  = cmd_valid_i && cmd_code_i == CODE_BLK_ERASE;
    is_prog = cmd_valid_i && cmd_code_i == CODE_PAGE_PROG;
    is_rd   = cmd_valid_i && cmd_code_i == CODE_READ;
    is_susp = cmd_valid_i && cmd_code_i == CODE_SUSPEND;
    is_res  = cmd_valid_i && cmd_code_i == CODE_RESUME;
    if (is_sec)       cmd_kind = KIND_SEC;
    else if (is_blk)  cmd_kind = KIND_BLK;
    else if (is_prog) cmd_kind = KIND_PAGE;
    else              cmd_kind = KIND_BYTE;
  end

  flash_region_cmp #(
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W),
    .SEC_W  (SEC_W),
    .BLK_W  (BLK_W)
  ) u_region (
    .kind_a_i (cmd_kind),
    .addr_a_i (cmd_addr_i),
    .kind_b_i (sus_kind_q),
    .addr_b_i (sus_addr_q),
    .same_o   (hit)
  );

  flash_op_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .tick_i     (tick_i),
    .rem_o      (rem)
  );

  flash_lat_cnt #(.SUSP_LAT(SUSP_LAT)) u_lat (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (acc_susp),
    .busy_o  (lat_busy)
  );

  always_comb begin
    running   = rem != '0;
    busy_o    = running || lat_busy;
    finishing = tick_i && rem == CNT_W'(1);
    sus_erase = sus_kind_q != KIND_PAGE;

    acc_susp  = is_susp && running && !lat_busy && !sus_valid_q && !finishing;
    acc_res   = is_res && !busy_o && sus_valid_q;
    acc_erase = (is_sec || is_blk) && !busy_o &&
                !(sus_valid_q && (sus_erase || hit));
    acc_prog  = is_prog && !busy_o &&
                !(sus_valid_q && (!sus_erase || hit));
    acc_rd    = is_rd && !busy_o;
    acc_any   = acc_susp || acc_res || acc_erase || acc_prog || acc_rd;

    tmr_load = acc_susp || acc_res || acc_erase || acc_prog;
    if (acc_res)        tmr_val = sus_rem_q;
    else if (is_sec)    tmr_val = CNT_W'(SEC_TICKS);
    else if (is_blk)    tmr_val = CNT_W'(BLK_TICKS);
    else if (acc_prog)  tmr_val = CNT_W'(PROG_TICKS);
    else                tmr_val = '0;  // suspend freezes the timer
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_kind_q   <= KIND_SEC;
      act_addr_q   <= '0;
      sus_kind_q   <= KIND_SEC;
      sus_addr_q   <= '0;
      sus_rem_q    <= '0;
      sus_valid_q  <= 1'b0;
      cmd_ack_o    <= 1'b0;
      cmd_nak_o    <= 1'b0;
      rd_invalid_o <= 1'b0;
    end else begin
      cmd_ack_o    <= acc_any;
      cmd_nak_o    <= cmd_valid_i && !acc_any;
      rd_invalid_o <= acc_rd && sus_valid_q && hit;
      if (acc_erase || acc_prog) begin
        act_kind_q <= cmd_kind;
        act_addr_q <= cmd_addr_i;
      end
      if (acc_susp) begin
        sus_valid_q <= 1'b1;
        sus_kind_q  <= act_kind_q;
        sus_addr_q  <= act_addr_q;
        sus_rem_q   <= tick_i ? rem - CNT_W'(1) : rem;
      end
      if (acc_res) begin
        sus_valid_q <= 1'b0;
        act_kind_q  <= sus_kind_q;
        act_addr_q  <= sus_addr_q;
      end
    end
  end

  assign erase_susp_o = sus_valid_q && sus_erase;
  assign prog_susp_o  = sus_valid_q && !sus_erase;
endmodule

// File: rtl/flash_write_engine_chk.sv
module flash_write_engine_chk
  import flash_we_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [7:0]       cmd_code_i,
  input logic             busy_o,
  input logic             erase_susp_o,
  input logic             prog_susp_o,
  input logic             cmd_ack_o,
  input logic             cmd_nak_o,
  input logic             rd_invalid_o,
  input logic [CNT_W-1:0] rem_i,
  input logic             tmr_load_i
);
  logic any_susp;
  assign any_susp = erase_susp_o || prog_susp_o;

  assert_one_reply_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> (cmd_ack_o != cmd_nak_o));

  assert_no_stray_reply_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> (!cmd_ack_o && !cmd_nak_o));

  assert_flags_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(erase_susp_o && prog_susp_o));

  assert_susp_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(any_susp) |-> (busy_o && cmd_ack_o));

  assert_busy_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && busy_o && cmd_code_i != CODE_SUSPEND) |=> cmd_nak_o);

  assert_resume_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(any_susp) |-> (busy_o && cmd_ack_o));

  assert_timer_mono_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rem_i != '0 && !tmr_load_i) |=> (rem_i <= $past(rem_i)));

  assert_rd_invalid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_invalid_o |-> (cmd_ack_o && any_susp));
endmodule

bind flash_write_engine flash_write_engine_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_i),
  .cmd_code_i   (cmd_code_i),
  .busy_o       (busy_o),
  .erase_susp_o (erase_susp_o),
  .prog_susp_o  (prog_susp_o),
  .cmd_ack_o    (cmd_ack_o),
  .cmd_nak_o    (cmd_nak_o),
  .rd_invalid_o (rd_invalid_o),
  .rem_i        (rem),
  .tmr_load_i   (tmr_load)
);

// File: tb/flash_write_engine_bench.sv
module flash_write_engine_bench;
  localparam int AW = 16;
  localparam int SEC_T = 12, BLK_T = 20, PRG_T = 8, LAT = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, valid = 1'b0;
  logic [7:0] code = 8'h00;
  logic [AW-1:0] addr = '0;
  logic busy, esus, psus, ack, nak, rdinv;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_write_engine #(
    .ADDR_W(AW), .PAGE_W(4), .SEC_W(8), .BLK_W(12),
    .SEC_TICKS(SEC_T), .BLK_TICKS(BLK_T), .PROG_TICKS(PRG_T), .SUSP_LAT(LAT)
  ) u_flash_write_engine (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .cmd_valid_i(valid),
    .cmd_code_i(code), .cmd_addr_i(addr), .busy_o(busy),
    .erase_susp_o(esus), .prog_susp_o(psus), .cmd_ack_o(ack),
    .cmd_nak_o(nak), .rd_invalid_o(rdinv)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // reference model: kinds 0 sector, 1 block, 2 page, 3 byte
  int m_rem = 0, m_lat = 0, m_sv = 0, m_sk = 0, m_sa = 0, m_srem = 0;
  int m_ak = 0, m_aa = 0, e_ack = 0, e_nak = 0, e_rdinv = 0;

  function automatic int gran(int k);
    case (k)
      0: return 8;
      1: return 12;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic bit same_region(int ka, int aa, int kb, int ab);
    int g = (gran(ka) > gran(kb)) ? gran(ka) : gran(kb);
    return (aa >> g) == (ab >> g);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rem = 0; m_lat = 0; m_sv = 0; m_sk = 0; m_sa = 0; m_srem = 0;
      m_ak = 0; m_aa = 0; e_ack = 0; e_nak = 0; e_rdinv = 0;
    end else begin
      bit bsy, h, a_s, a_r, a_e, a_p, a_d;
      int k;
      bsy = (m_rem > 0) || (m_lat > 0);
      k = (code == 8'h20) ? 0 : (code == 8'hD8) ? 1 : (code == 8'h02) ? 2 : 3;
      h = (m_sv != 0) && same_region(k, int'(addr), m_sk, m_sa);
      a_s = valid && code == 8'hB0 && m_rem > 0 && m_lat == 0 && m_sv == 0 &&
            !(tick && m_rem == 1);
      a_r = valid && code == 8'h30 && !bsy && m_sv != 0;
      a_e = valid && (code == 8'h20 || code == 8'hD8) && !bsy &&
            !(m_sv != 0 && (m_sk != 2 || h));
      a_p = valid && code == 8'h02 && !bsy && !(m_sv != 0 && (m_sk == 2 || h));
      a_d = valid && code == 8'h03 && !bsy;
      e_ack = int'(a_s || a_r || a_e || a_p || a_d);
      e_nak = int'(valid && e_ack == 0);
      e_rdinv = int'(a_d && h);
      if (m_lat > 0) m_lat--;
      if (a_s) begin
        m_srem = tick ? m_rem - 1 : m_rem;
        m_sk = m_ak; m_sa = m_aa; m_sv = 1; m_rem = 0; m_lat = LAT;
      end else if (a_e || a_p) begin
        m_rem = (k == 0) ? SEC_T : (k == 1) ? BLK_T : PRG_T;
        m_ak = k; m_aa = int'(addr);
      end else if (a_r) begin
        m_rem = m_srem; m_ak = m_sk; m_aa = m_sa; m_sv = 0;
      end else if (tick && m_rem > 0) begin
        m_rem--;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R1 ack", int'(ack), e_ack);
      check("R1 nak", int'(nak), e_nak);
      check("R2 busy", int'(busy), int'(m_rem > 0 || m_lat > 0));
      check("R3 erase flag", int'(esus), int'(m_sv != 0 && m_sk != 2));
      check("R3 prog flag", int'(psus), int'(m_sv != 0 && m_sk == 2));
      check("R11 rd_invalid", int'(rdinv), e_rdinv);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // one command or idle cycle; results are visible on return
  task automatic step(bit v, logic [7:0] c, int a, bit t);
    @(negedge clk);
    valid = v; code = c; addr = AW'(a); tick = t;
    @(posedge clk);
    #1;
    valid = 0; tick = 0;
  endtask

  task automatic cmd(logic [7:0] c, int a);
    step(1, c, a, 0);
  endtask

  task automatic idle(bit t);
    step(0, 8'h00, 0, t);
  endtask

  task automatic ticks_to_idle(output int n);
    n = 0;
    for (int i = 0; i < 60 && busy; i++) begin
      idle(1);
      n++;
    end
  endtask

  int n;

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R12 busy", int'(busy), 0);
    check("R12 flags", int'(esus | psus), 0);
    check("R12 replies", int'(ack | nak | rdinv), 0);
    @(negedge clk); rst_n = 1;

    cmd(8'h03, 16'h0100); check("R11 read idle ack", int'(ack), 1);
    check("R11 read idle valid", int'(rdinv), 0);
    cmd(8'hB0, 0);        check("R6 suspend idle", int'(nak), 1);
    cmd(8'h30, 0);        check("R7 resume nothing", int'(nak), 1);
    cmd(8'h55, 0);        check("R1 unknown code", int'(nak), 1);

    // sector erase, suspend after 5 ticks
    cmd(8'h20, 16'h1234); check("R2 erase busy", int'(busy), 1);
    repeat (5) idle(1);
    cmd(8'h02, 16'h3000); check("R5 prog while busy", int'(nak), 1);
    cmd(8'hB0, 0);        check("R3 suspend ack", int'(ack), 1);
    check("R3 erase flag set", int'(esus), 1);
    cmd(8'hB0, 0);        check("R6 suspend in latency", int'(nak), 1);
    check("R4 latency busy", int'(busy), 1);
    idle(0);              check("R4 latency busy end-1", int'(busy), 1);
    idle(0);              check("R4 latency over", int'(busy), 0);

    cmd(8'h03, 16'h1200); check("R11 read suspended sector", int'(rdinv), 1);
    cmd(8'h03, 16'h2000); check("R11 read other sector", int'(rdinv), 0);
    cmd(8'h02, 16'h1250); check("R9 prog in suspended sector", int'(nak), 1);
    cmd(8'h20, 16'h4000); check("R9 erase while erase suspended", int'(nak), 1);
    cmd(8'h02, 16'h2010); check("R9 prog elsewhere", int'(ack), 1);
    cmd(8'hB0, 0);        check("R6 suspend while suspended", int'(nak), 1);
    ticks_to_idle(n);     check("R2 program duration", n, PRG_T);
    check("R9 erase flag kept", int'(esus), 1);

    cmd(8'h30, 0);        check("R7 resume ack", int'(ack), 1);
    check("R7 flag cleared", int'(esus), 0);
    check("R7 busy", int'(busy), 1);
    ticks_to_idle(n);     check("R8 remaining erase ticks", n, SEC_T - 5);

    // page program, suspend after 3 ticks
    cmd(8'h02, 16'h5030);
    repeat (3) idle(1);
    cmd(8'hB0, 0);        check("R3 prog flag set", int'(psus), 1);
    repeat (3) idle(0);
    check("R4 latency done", int'(busy), 0);
    cmd(8'hD8, 16'h5000); check("R10 block holds page", int'(nak), 1);
    cmd(8'h20, 16'h5100); check("R10 erase elsewhere", int'(ack), 1);
    ticks_to_idle(n);     check("R2 sector duration", n, SEC_T);
    cmd(8'h02, 16'h7000); check("R10 prog while prog suspended", int'(nak), 1);
    cmd(8'h03, 16'h5035); check("R11 read suspended page", int'(rdinv), 1);
    cmd(8'h03, 16'h5100); check("R11 read beside page", int'(rdinv), 0);
    cmd(8'h30, 0);        check("R7 resume prog", int'(psus), 0);
    ticks_to_idle(n);     check("R8 remaining prog ticks", n, PRG_T - 3);

    // suspend on the completing tick
    cmd(8'h02, 16'h6000);
    repeat (PRG_T - 1) idle(1);
    step(1, 8'hB0, 0, 1); check("R6 suspend at completion", int'(nak), 1);
    check("R6 done not suspended", int'(busy | psus), 0);

    cmd(8'hD8, 16'h8000); ticks_to_idle(n);
    check("R2 block duration", n, BLK_T);

    repeat (2) idle(0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule